// File: doc/BRIEF.md
# Biopotential Converter SPI Slave Emulator

This block stands in for an eight-channel, 24-bit biopotential front-end converter on the serial side, so that a controller design can be exercised in simulation or on a board without the real converter. It answers on an SPI slave port (serial clock, active-low chip select, master-out data, master-in data) and drives an active-low data-ready line. All serial inputs are resynchronised into the system clock domain and edge-detected there, so the serial clock must run well below the system clock.

The emulator holds 26 eight-bit configuration registers, reachable through burst read and burst write commands. A continuous-read command makes it announce a new sample frame once per sample period on data-ready; each frame is 27 bytes long and carries counter-generated data rather than analog values. A standby command puts it to sleep after a delay, and a wake-up command brings it back after a second delay. A reset command restores the register defaults. The sample period and both delays are parameters given in system clock cycles; the default period gives 500 frames per second at 200 MHz.

Top module: `bioadc_emu_top`

## Requirements
- R1: After reset, data-ready is high, MISO is low, the block is awake and not streaming, register 0 reads 0x92 and every other register reads 0x00.
- R2: Opcode 001aaaaa starts a burst read at address aaaaa; the next byte holds count minus one; the following count bytes return consecutive registers MSB first on MISO, each bit valid from just after the previous SCLK rising edge until the next one.
- R3: Opcode 010aaaaa starts a burst write at address aaaaa; the next byte holds count minus one; the following count MOSI bytes, sampled on SCLK rising edges, are written to consecutive addresses.
- R4: Register 0 is read-only, addresses 26 to 31 read 0x00 and drop writes, and bytes beyond the burst count read 0x00 and are not written.
- R5: After opcode 0x10 (start streaming) data-ready falls every SAMPLE_DIV system clock cycles; it returns high on the first SCLK rising edge with chip select low, or one cycle before the next fall.
- R6: Each streamed frame is 27 bytes: 0xC0, 0x00, 0x00, then for channel k = 0..7 the bytes k, count[15:8], count[7:0], where count is 0 in the first frame after streaming starts and rises by one per frame; bytes after the 27th read 0x00.
- R7: While streaming, every received byte other than 0x11 is ignored, including register writes.
- R8: Opcode 0x11 ends streaming; data-ready then stays high.
- R9: Opcode 0x04 enters standby after ENTER_DLY cycles; during the entry delay and while asleep every command except wake-up 0x02 is ignored, and data-ready stays high.
- R10: After 0x02 in standby, commands stay ignored for WAKE_DLY cycles, after which the block answers register commands again.
- R11: Opcode 0x06 restores all register defaults.
- R12: Raising chip select aborts any partial byte and command; MISO is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| drdy_n | output | 1 | Active-low frame-ready indication |

## Verification
The hardest condition to reach is the window just after wake-up, when the block is no longer asleep yet still deaf to commands; the stimulus issues a register read immediately after the wake-up byte, inside that window, and repeats it once the window has passed. A second hard case is a register write sent while streaming, whose absence of effect only shows after streaming is stopped and the register is read back. Frame content is checked by starting a transfer right after data-ready falls, so the 27 bytes are read before the next period latches a new count.

// File: rtl/bioadc_emu_pkg.sv
package bioadc_emu_pkg;

    typedef enum logic [1:0] {
        PW_RUN,
        PW_ENTER,
        PW_SLEEP,
        PW_WAKE
    } pwr_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_CNT,
        PH_DATA
    } phase_e;

    localparam logic [7:0] OP_WAKEUP  = 8'h02;
    localparam logic [7:0] OP_STANDBY = 8'h04;
    localparam logic [7:0] OP_RESET   = 8'h06;
    localparam logic [7:0] OP_STREAM  = 8'h10;
    localparam logic [7:0] OP_HALT    = 8'h11;
    localparam logic [2:0] OP_RD_HI   = 3'b001;
    localparam logic [2:0] OP_WR_HI   = 3'b010;

    localparam logic [7:0] STATUS_HDR  = 8'hC0;
    localparam logic [4:0] FRAME_BYTES = 5'd27;

endpackage

// File: rtl/bioadc_emu_spi_rx.sv
module bioadc_emu_spi_rx #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       cs_act,
    output logic       sclk_rise,
    output logic       byte_stb,
    output logic [7:0] byte_val,
    output logic [2:0] bitcnt
);

    typedef struct packed {
        logic [SYNC:0]   sclk;
        logic [SYNC-1:0] cs;
        logic [SYNC-1:0] mosi;
        logic [6:0]      shift;
        logic [2:0]      bits;
        logic            stb;
        logic [7:0]      data;
    } rx_t;

    rx_t q, d;
    logic rise_w;
    logic mosi_w;

    assign cs_act    = ~q.cs[SYNC-1];
    assign rise_w    = q.sclk[SYNC-1] & ~q.sclk[SYNC];
    assign mosi_w    = q.mosi[SYNC-1];
    assign sclk_rise = rise_w & cs_act;
    assign byte_stb  = q.stb;
    assign byte_val  = q.data;
    assign bitcnt    = q.bits;

    always_comb begin
        d      = q;
        d.sclk = {q.sclk[SYNC-1:0], sclk};
        d.cs   = {q.cs[SYNC-2:0], cs_n};
        d.mosi = {q.mosi[SYNC-2:0], mosi};
        d.stb  = 1'b0;
        if (!cs_act) begin
            d.bits  = 3'd0;
            d.shift = 7'd0;
        end else if (rise_w) begin
            d.shift = {q.shift[5:0], mosi_w};
            d.bits  = q.bits + 3'd1;
            if (q.bits == 3'd7) begin
                d.stb  = 1'b1;
                d.data = {q.shift, mosi_w};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cs    <= '1;
        end else begin
            q <= d;
        end
    end

    // R12: a deselected port holds no partial byte
    p_bits_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (bitcnt == 3'd0));

    // R2: a byte strobe never repeats on consecutive cycles
    p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb);

endmodule

// File: rtl/bioadc_emu_regs.sv
module bioadc_emu_regs #(
    parameter int         NREG = 26,
    parameter int         AW   = 5,
    parameter logic [7:0] ID   = 8'h92
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [NREG];
    logic [7:0] mem_d [NREG];

    function automatic logic [7:0] dflt(input int i);
        return (i == 0) ? ID : 8'h00;
    endfunction

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (clr) begin
            for (int i = 0; i < NREG; i++) begin
                mem_d[i] = dflt(i);
            end
        end else if (we && (waddr != '0) && (int'(waddr) < NREG)) begin
            mem_d[int'(waddr)] = wdata;
        end
    end

    assign rdata = (int'(raddr) < NREG) ? mem_q[int'(raddr)] : 8'h00;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mem_q[g] <= dflt(g);
                else        mem_q[g] <= mem_d[g];
            end
        end
    endgenerate

    // R4: identification register cannot be overwritten
    p_id_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0) |=> (mem_q[0] == ID));

    // R11: a clear leaves the last register at its default
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mem_q[NREG-1] == dflt(NREG-1)));

endmodule

// File: rtl/bioadc_emu_top.sv
module bioadc_emu_top
    import bioadc_emu_pkg::*;
#(
    parameter int         NREG       = 26,
    parameter logic [7:0] ID         = 8'h92,
    parameter int         SAMPLE_DIV = 400000,
    parameter int         ENTER_DLY  = 1800,
    parameter int         WAKE_DLY   = 1800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic drdy_n
);

    localparam int AW   = 5;
    localparam int CW   = $clog2(SAMPLE_DIV);
    localparam int DMAX = (ENTER_DLY > WAKE_DLY) ? ENTER_DLY : WAKE_DLY;
    localparam int DW   = $clog2(DMAX + 1);

    typedef struct packed {
        pwr_e          pwr;
        phase_e        phase;
        logic          is_wr;
        logic [AW-1:0] addr;
        logic [8:0]    remain;
        logic          stream;
        logic [CW-1:0] per;
        logic [15:0]   samp;
        logic [15:0]   frame;
        logic          rdy_n;
        logic [DW-1:0] dly;
        logic [4:0]    fidx;
    } st_t;

    st_t q, d;

    logic       cs_act, sclk_rise, byte_stb;
    logic [7:0] byte_val, reg_rdata, tx;
    logic [2:0] bitcnt;
    logic       reg_we, reg_clr, tick;

    bioadc_emu_spi_rx #(.SYNC(2)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .cs_act(cs_act), .sclk_rise(sclk_rise), .byte_stb(byte_stb),
        .byte_val(byte_val), .bitcnt(bitcnt)
    );

    bioadc_emu_regs #(.NREG(NREG), .AW(AW), .ID(ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr(reg_clr), .we(reg_we),
        .waddr(q.addr), .wdata(byte_val), .raddr(q.addr), .rdata(reg_rdata)
    );

    function automatic logic [7:0] frame_byte(input logic [4:0] idx, input logic [15:0] cnt);
        int k;
        if (idx == 5'd0) return STATUS_HDR;
        if (idx < 5'd3 || idx >= FRAME_BYTES) return 8'h00;
        k = int'(idx) - 3;
        case (k % 3)
            0:       return 8'(k / 3);
            1:       return cnt[15:8];
            default: return cnt[7:0];
        endcase
    endfunction

    assign tick = q.stream && (q.pwr == PW_RUN) && (q.per == CW'(SAMPLE_DIV - 1));

    always_comb begin
        d       = q;
        reg_we  = 1'b0;
        reg_clr = 1'b0;

        d.per = (q.stream && !tick) ? q.per + 1'b1 : '0;
        if (tick) begin
            d.rdy_n = 1'b0;
            d.frame = q.samp;
            d.samp  = q.samp + 16'd1;
        end else if (sclk_rise || !q.stream || q.per == CW'(SAMPLE_DIV - 2)) begin
            d.rdy_n = 1'b1;
        end

        case (q.pwr)
            PW_ENTER: begin
                d.dly = q.dly + 1'b1;
                if (q.dly == DW'(ENTER_DLY - 1)) begin d.pwr = PW_SLEEP; d.dly = '0; end
            end
            PW_WAKE: begin
                d.dly = q.dly + 1'b1;
                if (q.dly == DW'(WAKE_DLY - 1)) begin d.pwr = PW_RUN; d.dly = '0; end
            end
            default: ;
        endcase

        if (!cs_act) begin
            d.phase = PH_CMD;
            d.fidx  = '0;
        end else if (byte_stb) begin
            if (q.fidx != 5'd31) d.fidx = q.fidx + 5'd1;
            if (q.pwr == PW_SLEEP) begin
                if (byte_val == OP_WAKEUP) begin d.pwr = PW_WAKE; d.dly = '0; end
            end else if (q.pwr == PW_RUN) begin
                if (q.stream) begin
                    if (byte_val == OP_HALT) d.stream = 1'b0;
                end else begin
                    case (q.phase)
                        PH_CMD: begin
                            if (byte_val[7:5] == OP_RD_HI || byte_val[7:5] == OP_WR_HI) begin
                                d.is_wr = (byte_val[7:5] == OP_WR_HI);
                                d.addr  = byte_val[4:0];
                                d.phase = PH_CNT;
                            end else if (byte_val == OP_STANDBY) begin
                                d.pwr = PW_ENTER;
                                d.dly = '0;
                            end else if (byte_val == OP_RESET) begin
                                reg_clr = 1'b1;
                                d.samp  = '0;
                            end else if (byte_val == OP_STREAM) begin
                                d.stream = 1'b1;
                                d.samp   = '0;
                                d.per    = '0;
                            end
                        end
                        PH_CNT: begin
                            d.remain = {1'b0, byte_val} + 9'd1;
                            d.phase  = PH_DATA;
                        end
                        default: begin
                            if (q.remain != 9'd0) begin
                                reg_we   = q.is_wr;
                                d.addr   = q.addr + 1'b1;
                                d.remain = q.remain - 9'd1;
                            end
                        end
                    endcase
                end
            end
        end
    end

    always_comb begin
        if (q.stream)
            tx = frame_byte(q.fidx, q.frame);
        else if (q.pwr == PW_RUN && q.phase == PH_DATA && !q.is_wr && q.remain != 9'd0)
            tx = reg_rdata;
        else
            tx = 8'h00;
    end

    assign spi_miso = cs_act ? tx[3'd7 - bitcnt] : 1'b0;
    assign drdy_n   = q.rdy_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.pwr   <= PW_RUN;
            q.phase <= PH_CMD;
            q.rdy_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R8: no frame indication unless streaming
    p_rdy_needs_stream_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.stream |=> drdy_n);

    // R7: only the halt opcode leaves streaming
    p_stream_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stream && byte_stb && byte_val != OP_HALT) |=> q.stream);

    // R9: sleep is left only through wake-up
    p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pwr == PW_SLEEP && !(byte_stb && cs_act && byte_val == OP_WAKEUP)) |=> (q.pwr == PW_SLEEP));

    // R10: waking never falls back to sleep
    p_wake_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pwr == PW_WAKE) |=> (q.pwr == PW_WAKE || q.pwr == PW_RUN));

endmodule

// File: tb/tb_bioadc_emu_top.sv
`timescale 1ns/1ps
module tb_bioadc_emu_top;

    localparam int DIV  = 6000;
    localparam int ENT  = 200;
    localparam int WK   = 2000;
    localparam int HALF = 8;
    localparam int NV   = 6;

    // {address, write data, expected read-back}
    localparam logic [20:0] VEC [NV] = '{
        {5'd1,  8'h5A, 8'h5A},
        {5'd25, 8'hFF, 8'hFF},
        {5'd0,  8'h33, 8'h92},
        {5'd26, 8'h11, 8'h00},
        {5'd12, 8'h81, 8'h81},
        {5'd31, 8'h07, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, drdy_n;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    bioadc_emu_top #(.SAMPLE_DIV(DIV), .ENTER_DLY(ENT), .WAKE_DLY(WK)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .drdy_n(drdy_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0; wclk(HALF);
    endtask

    task automatic desel();
        wclk(HALF); cs_n = 1'b1; wclk(2 * HALF);
    endtask

    task automatic xfer(input logic [7:0] t, output logic [7:0] r);
        for (int b = 7; b >= 0; b--) begin
            mosi = t[b];
            wclk(HALF);
            r[b] = miso;
            sclk = 1'b1;
            wclk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel(); xfer(op, r); desel();
    endtask

    task automatic wr1(input logic [4:0] a, input logic [7:0] v);
        logic [7:0] r;
        sel(); xfer({3'b010, a}, r); xfer(8'h00, r); xfer(v, r); desel();
    endtask

    task automatic rd1(input logic [4:0] a, output logic [7:0] v);
        logic [7:0] r;
        sel(); xfer({3'b001, a}, r); xfer(8'h00, r); xfer(8'h00, v); desel();
    endtask

    function automatic logic [7:0] fexp(input int idx, input logic [15:0] cnt);
        if (idx == 0) return 8'hC0;
        if (idx < 3 || idx >= 27) return 8'h00;
        case ((idx - 3) % 3)
            0:       return 8'((idx - 3) / 3);
            1:       return cnt[15:8];
            default: return cnt[7:0];
        endcase
    endfunction

    task automatic read_frame(input logic [15:0] cnt, input string tag);
        logic [7:0] r;
        int bad = 0;
        logic [7:0] first_bad_a = 0, first_bad_e = 0;
        sel();
        for (int i = 0; i < 28; i++) begin
            xfer(8'h00, r);
            if (i == 0) chk("R5 drdy high after first SCLK", {31'd0, drdy_n}, 1);
            if (r !== fexp(i, cnt) && bad == 0) begin
                bad = 1; first_bad_a = r; first_bad_e = fexp(i, cnt);
            end
        end
        desel();
        chk(tag, {24'd0, first_bad_a}, {24'd0, first_bad_e});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        bit seen;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);

        // R1 reset state
        chk("R1 drdy_n", {31'd0, drdy_n}, 1);
        chk("R1 miso", {31'd0, miso}, 0);
        rd1(5'd0, v); chk("R1 id register", {24'd0, v}, 32'h92);
        rd1(5'd7, v); chk("R1 default zero", {24'd0, v}, 0);

        // R3 R4 table of single writes and read-backs
        for (int i = 0; i < NV; i++) begin
            wr1(VEC[i][20:16], VEC[i][15:8]);
            rd1(VEC[i][20:16], v);
            chk("R3/R4 table", {24'd0, v}, {24'd0, VEC[i][7:0]});
        end

        // R2 R3 bursts, R4 bytes beyond count
        begin
            logic [7:0] r;
            sel(); xfer({3'b010, 5'd2}, r); xfer(8'd2, r);
            xfer(8'hAA, r); xfer(8'hBB, r); xfer(8'hCC, r); xfer(8'hDD, r); desel();
            sel(); xfer({3'b001, 5'd2}, r); xfer(8'd4, r);
            xfer(8'h00, r); chk("R2 burst byte0", {24'd0, r}, 32'hAA);
            xfer(8'h00, r); chk("R2 burst byte1", {24'd0, r}, 32'hBB);
            xfer(8'h00, r); chk("R2 burst byte2", {24'd0, r}, 32'hCC);
            xfer(8'h00, r); chk("R4 beyond write count", {24'd0, r}, 0);
            xfer(8'h00, r); chk("R4 beyond read count", {24'd0, r}, 0);
            desel();
            sel(); xfer({3'b010, 5'd24}, r); xfer(8'd2, r);
            xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); desel();
            sel(); xfer({3'b001, 5'd24}, r); xfer(8'd2, r);
            xfer(8'h00, r); chk("R2 reg24", {24'd0, r}, 32'h11);
            xfer(8'h00, r); chk("R2 reg25", {24'd0, r}, 32'h22);
            xfer(8'h00, r); chk("R4 reg26 empty", {24'd0, r}, 0);
            desel();
        end

        // R12 aborted partial byte
        sel();
        for (int b = 0; b < 3; b++) begin
            mosi = 1'b1; wclk(HALF); sclk = 1'b1; wclk(HALF); sclk = 1'b0;
        end
        desel();
        chk("R12 miso idle", {31'd0, miso}, 0);
        rd1(5'd1, v); chk("R12 after abort", {24'd0, v}, 32'h5A);

        // R11 reset command
        wr1(5'd5, 8'h44);
        cmd1(8'h06);
        rd1(5'd5, v); chk("R11 reg5 default", {24'd0, v}, 0);
        rd1(5'd1, v); chk("R11 reg1 default", {24'd0, v}, 0);
        rd1(5'd0, v); chk("R11 id kept", {24'd0, v}, 32'h92);

        // R5 R6 streaming
        wr1(5'd1, 8'h3C);
        cmd1(8'h10);
        @(negedge drdy_n);
        read_frame(16'd0, "R6 frame 0");
        @(negedge drdy_n);
        read_frame(16'd1, "R6 frame 1");
        n = 0;
        @(negedge drdy_n);
        @(negedge clk);
        do begin @(negedge clk); n++; end while (drdy_n == 1'b0);
        do begin @(negedge clk); n++; end while (drdy_n == 1'b1);
        chk("R5 period", n, DIV);

        // R7 write ignored while streaming
        begin
            logic [7:0] r;
            sel(); xfer({3'b010, 5'd1}, r); xfer(8'h00, r); xfer(8'h77, r); desel();
        end
        cmd1(8'h11);
        rd1(5'd1, v); chk("R7 write ignored", {24'd0, v}, 32'h3C);

        // R8 halted: drdy stays high
        seen = 0;
        for (int i = 0; i < DIV + 100; i++) begin
            @(negedge clk); if (!drdy_n) seen = 1;
        end
        chk("R8 no drdy after halt", {31'd0, seen}, 0);

        // R9 standby
        cmd1(8'h04);
        wclk(ENT + 50);
        rd1(5'd0, v); chk("R9 read ignored asleep", {24'd0, v}, 0);
        cmd1(8'h10);
        seen = 0;
        for (int i = 0; i < 2 * DIV; i++) begin
            @(negedge clk); if (!drdy_n) seen = 1;
        end
        chk("R9 no stream asleep", {31'd0, seen}, 0);

        // R10 wake-up latency
        cmd1(8'h02);
        rd1(5'd0, v); chk("R10 still waking", {24'd0, v}, 0);
        wclk(WK);
        rd1(5'd0, v); chk("R10 awake", {24'd0, v}, 32'h92);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule